// File: doc/BRIEF.md
# Oversampling ADC Conversion Sequencer

This block controls a one-bit oversampling converter. It owns a bank of eight byte-wide registers on a plain address/data bus. Six registers hold configuration and two are read-only and return the signed 16-bit result. A conversion is a series of elementary conversions. In each one, a programmable number of modulator bits is taken on a sample strobe. The strobe is derived from the clock, or from a slow external tick. Each bit adds +1 or -1 to a running sum. The modulator input polarity is reversed between elementary conversions, so a constant offset cancels out.

Software requests a single conversion with a self-clearing request bit, or sets a continuous bit to re-arm conversions back to back. The block drives the polarity (chop) control, the modulator enable and the sample strobe. It passes three amplifier enables through. It flags completion with a one-cycle done pulse and a busy level.

Top module: `osadc_ctrl`

## Requirements
- R1: Addresses are 0 = result bits 7:0, 1 = result bits 15:8, and 2..7 = configuration registers C0..C5. After reset, C0 reads 0x28, C1 reads 0xF1, C2..C5 read 0x00 and both result bytes read 0x00.
- R2: C0 holds the request bit at bit 7, the count exponent N at bits 6:5, the rate exponent M at bits 4:2, the continuous bit at bit 1 and a test bit at bit 0. Bits 7 and 0 always read 0. Writes to addresses 0 and 1 leave the result unchanged.
- R3: Writing 1 to C0 bit 7 while idle starts exactly one conversion. It ends with a one-cycle `done` pulse and the new result readable.
- R4: Each sample adds +1 when `mod_bit` XOR `chop` is 1 and -1 otherwise. `chop` is 0 in the first elementary conversion and toggles before each following one. The result is the signed sum saturated to 16 bits, in two's complement.
- R5: A conversion has 2^N elementary conversions of 2^(3+M) samples each.
- R6: C2 bits 7:6 select the strobe. Codes 0, 1 and 2 give one strobe every 4, 8 and 32 clocks. Code 3 gives one strobe per `slow_tick` pulse.
- R7: A request written while busy is held and runs after the current conversion. Any number of requests during one conversion yield one extra conversion only.
- R8: While C0 bit 1 is 1, a new conversion starts after each one completes. After it is cleared, the conversion in progress finishes and no further one starts.
- R9: While C1 bit 0 is 0, `mod_en` is 0, no strobes occur and no conversion runs. A pending request is kept and runs once the bit is set. `amp_en` always equals C1 bits 3:1.
- R10: `busy` is 1 from the launch of a conversion until its result is stored. C5 bit 7 reads `busy`, and C5 bits 6:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| mod_bit | input | 1 | Modulator output bit |
| slow_tick | input | 1 | One-cycle pulse at the slow sampling rate |
| mod_en | output | 1 | Modulator enable |
| amp_en | output | 3 | Amplifier stage enables |
| chop | output | 1 | Input polarity reversal control |
| sample_stb | output | 1 | Sample strobe |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is stored |

## Verification
The assertions assume `slow_tick` is a single-cycle pulse with gaps of several clocks, and that `mod_bit` is only significant on strobe cycles. The bench generates the tick as one high cycle in fifty. It drives `mod_bit` either as a constant or as a fixed function of `chop`, so every expected sum follows from N, M and that rule alone. Register writes last one cycle, and the configuration changes only while the block is idle.

// File: rtl/osadc_pkg.sv
package osadc_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;
  localparam int DIV_W  = 5;

  localparam logic [REG_AW-1:0] A_RES_LO = 3'd0;
  localparam logic [REG_AW-1:0] A_RES_HI = 3'd1;
  localparam logic [REG_AW-1:0] A_C0     = 3'd2;
  localparam logic [REG_AW-1:0] A_C1     = 3'd3;
  localparam logic [REG_AW-1:0] A_C2     = 3'd4;
  localparam logic [REG_AW-1:0] A_C3     = 3'd5;
  localparam logic [REG_AW-1:0] A_C4     = 3'd6;
  localparam logic [REG_AW-1:0] A_C5     = 3'd7;

  typedef enum logic [1:0] {
    FS_DIV4  = 2'd0,
    FS_DIV8  = 2'd1,
    FS_DIV32 = 2'd2,
    FS_SLOW  = 2'd3
  } fsel_e;

  // last count value of the strobe divider for a rate code
  function automatic logic [DIV_W-1:0] div_last(input fsel_e f);
    case (f)
      FS_DIV4:  return DIV_W'(3);
      FS_DIV8:  return DIV_W'(7);
      FS_DIV32: return DIV_W'(31);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/osadc_regs.sv
module osadc_regs
  import osadc_pkg::*;
#(
  parameter int NE_W  = 2,
  parameter int OE_W  = 3,
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic              busy,
  input  logic [OUT_W-1:0]  result,
  output logic              start_req,
  output logic [NE_W-1:0]   nelc_exp,
  output logic [OE_W-1:0]   osr_exp,
  output logic              cont,
  output logic [3:0]        enables,
  output fsel_e             fsel
);
  logic [REG_DW-1:0] c1_q, c2_q, c3_q, c4_q;
  logic [6:0]        c5_q;
  logic              wr_c0;

  assign wr_c0     = wr_en && (addr == A_C0);
  assign start_req = wr_c0 && wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nelc_exp <= NE_W'(1);
      osr_exp  <= OE_W'(2);
      cont     <= 1'b0;
      c1_q     <= 8'hF1;
      c2_q     <= '0;
      c3_q     <= '0;
      c4_q     <= '0;
      c5_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        A_C0: begin
          nelc_exp <= wdata[6:5];
          osr_exp  <= wdata[4:2];
          cont     <= wdata[1];
        end
        A_C1:    c1_q <= wdata;
        A_C2:    c2_q <= wdata;
        A_C3:    c3_q <= wdata;
        A_C4:    c4_q <= wdata;
        A_C5:    c5_q <= wdata[6:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_RES_LO: rdata = result[7:0];
      A_RES_HI: rdata = result[15:8];
      A_C0:     rdata = {1'b0, nelc_exp, osr_exp, cont, 1'b0};
      A_C1:     rdata = c1_q;
      A_C2:     rdata = c2_q;
      A_C3:     rdata = c3_q;
      A_C4:     rdata = c4_q;
      default:  rdata = {busy, c5_q};
    endcase
  end

  assign enables = c1_q[3:0];
  assign fsel    = fsel_e'(c2_q[7:6]);
endmodule

// File: rtl/osadc_strobe.sv
module osadc_strobe
  import osadc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  fsel_e fsel,
  input  logic  slow_tick,
  output logic  stb
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim = div_last(fsel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!en)          cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign stb = en && ((fsel == FS_SLOW) ? slow_tick : (cnt_q == lim));
endmodule

// File: rtl/osadc_seq.sv
module osadc_seq #(
  parameter int NE_W     = 2,
  parameter int OE_W     = 3,
  parameter int OSR_BASE = 3,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_req,
  input  logic             cont,
  input  logic [NE_W-1:0]  nelc_exp,
  input  logic [OE_W-1:0]  osr_exp,
  input  logic             stb,
  input  logic             mod_bit,
  output logic             busy,
  output logic             chop,
  output logic             launch,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  localparam int SAMP_W = OSR_BASE + (1 << OE_W) - 1;
  localparam int ELEM_W = (1 << NE_W) - 1;
  localparam int ACC_W  = SAMP_W + ELEM_W + 2;
  localparam int EXT_W  = ((ACC_W > OUT_W) ? ACC_W : OUT_W) + 1;

  function automatic logic [SAMP_W-1:0] samp_last(input logic [OE_W-1:0] e);
    return SAMP_W'((1 << (OSR_BASE + int'(e))) - 1);
  endfunction

  function automatic logic [ELEM_W-1:0] elem_last(input logic [NE_W-1:0] e);
    return ELEM_W'((1 << int'(e)) - 1);
  endfunction

  function automatic logic [OUT_W-1:0] sat(input logic signed [ACC_W-1:0] a);
    logic signed [EXT_W-1:0] x, hi, lo;
    x  = {{(EXT_W-ACC_W){a[ACC_W-1]}}, a};
    hi = {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    lo = ~hi;
    if (x > hi)      return hi[OUT_W-1:0];
    else if (x < lo) return lo[OUT_W-1:0];
    else             return x[OUT_W-1:0];
  endfunction

  logic                     run_q, pend_q;
  logic [SAMP_W-1:0]        samp_q, samp_end_q;
  logic [ELEM_W-1:0]        elem_q, elem_end_q;
  logic signed [ACC_W-1:0]  acc_q, acc_next;
  logic                     samp_wrap, last_elem;

  assign launch    = !run_q && en && (pend_q || cont);
  assign acc_next  = acc_q + ((mod_bit ^ chop) ? ACC_W'(1) : {ACC_W{1'b1}});
  assign samp_wrap = (samp_q == samp_end_q);
  assign last_elem = (elem_q == elem_end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (start_req) pend_q <= 1'b1;
    else if (launch)    pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      chop       <= 1'b0;
      samp_q     <= '0;
      samp_end_q <= '0;
      elem_q     <= '0;
      elem_end_q <= '0;
      acc_q      <= '0;
      done       <= 1'b0;
      result     <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        run_q <= 1'b0;
      end else if (launch) begin
        run_q      <= 1'b1;
        chop       <= 1'b0;
        samp_q     <= '0;
        elem_q     <= '0;
        acc_q      <= '0;
        samp_end_q <= samp_last(osr_exp);
        elem_end_q <= elem_last(nelc_exp);
      end else if (run_q && stb) begin
        acc_q <= acc_next;
        if (!samp_wrap) begin
          samp_q <= samp_q + 1'b1;
        end else if (!last_elem) begin
          samp_q <= '0;
          elem_q <= elem_q + 1'b1;
          chop   <= ~chop;
        end else begin
          run_q  <= 1'b0;
          done   <= 1'b1;
          result <= sat(acc_next);
        end
      end
    end
  end

  assign busy = run_q;
endmodule

// File: rtl/osadc_ctrl.sv
module osadc_ctrl
  import osadc_pkg::*;
#(
  parameter int NE_W     = 2,
  parameter int OE_W     = 3,
  parameter int OSR_BASE = 3,
  parameter int OUT_W    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       mod_bit,
  input  logic       slow_tick,
  output logic       mod_en,
  output logic [2:0] amp_en,
  output logic       chop,
  output logic       sample_stb,
  output logic       busy,
  output logic       done
);
  logic             start_req_w, cont_w, launch_w;
  logic [NE_W-1:0]  nelc_w;
  logic [OE_W-1:0]  osr_w;
  logic [3:0]       enables_w;
  fsel_e            fsel_w;
  logic [OUT_W-1:0] result_w;

  osadc_regs #(.NE_W(NE_W), .OE_W(OE_W), .OUT_W(OUT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .busy(busy), .result(result_w), .start_req(start_req_w),
    .nelc_exp(nelc_w), .osr_exp(osr_w), .cont(cont_w), .enables(enables_w),
    .fsel(fsel_w)
  );

  assign mod_en = enables_w[0];
  assign amp_en = enables_w[3:1];

  osadc_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .fsel(fsel_w),
    .slow_tick(slow_tick), .stb(sample_stb)
  );

  osadc_seq #(.NE_W(NE_W), .OE_W(OE_W), .OSR_BASE(OSR_BASE), .OUT_W(OUT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .start_req(start_req_w),
    .cont(cont_w), .nelc_exp(nelc_w), .osr_exp(osr_w), .stb(sample_stb),
    .mod_bit(mod_bit), .busy(busy), .chop(chop), .launch(launch_w),
    .done(done), .result(result_w)
  );
endmodule

// File: rtl/osadc_ctrl_chk.sv
module osadc_ctrl_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             stb,
  input logic             mod_en,
  input logic             chop,
  input logic             launch,
  input logic [1:0]       fsel,
  input logic [OUT_W-1:0] result
);
  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R9
  gate_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> !stb);

  // R9
  gate_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> !busy);

  // R4
  chop_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chop) |-> ($past(stb) || $past(launch)));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R6
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && fsel != 2'd3) |=> !stb);
endmodule

bind osadc_ctrl osadc_ctrl_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .stb(sample_stb),
  .mod_en(mod_en), .chop(chop), .launch(launch_w), .fsel(fsel_w),
  .result(result_w)
);

// File: tb/sim_osadc_ctrl.sv
module sim_osadc_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       mod_bit, slow_tick = 0;
  logic       mod_en, chop, sample_stb, busy, done;
  logic [2:0] amp_en;
  logic       md_track = 0, md_const = 0, md_inv = 0;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  // tracking: sign = md_inv on every sample
  assign mod_bit = md_track ? (chop ^ md_inv) : md_const;

  osadc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .mod_bit(mod_bit), .slow_tick(slow_tick), .mod_en(mod_en),
    .amp_en(amp_en), .chop(chop), .sample_stb(sample_stb), .busy(busy),
    .done(done)
  );

  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n = (n == 49) ? 0 : n + 1;
      slow_tick = (n == 49);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #2; d = rdata;
  endtask

  task automatic rd_res(output logic [15:0] r);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi); r = {hi, lo};
  endtask

  task automatic wait_done(input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk); #2;
      if (done) seen = 1;
    end
  endtask

  task automatic count_done(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #2;
      if (done) n++;
    end
  endtask

  task automatic conv(input string req, input logic [7:0] c0, input int lim,
                      input logic [15:0] exp);
    bit seen; logic [15:0] r;
    wr(3'd2, c0);
    wait_done(lim, seen);
    chk({req, " done seen"}, 32'(seen), 1);
    rd_res(r);
    chk({req, " result"}, 32'(r), 32'(exp));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h28, 8'hF1, 8'h00, 8'h00, 8'h00, 8'h00};
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset value", 32'(d), 32'(exp[a]));
    end
    chk("R10 busy after reset", 32'(busy), 0);
  endtask

  task automatic t_ro_bits();
    logic [7:0] d; logic [15:0] r0, r1;
    wr(3'd2, 8'h29);
    rd(3'd2, d);
    chk("R2 test bit ignored", 32'(d), 32'h28);
    chk("R2 no launch without request", 32'(busy), 0);
    rd_res(r0);
    wr(3'd0, 8'h55); wr(3'd1, 8'hAA);
    rd_res(r1);
    chk("R2 result read-only", 32'(r1), 32'(r0));
  endtask

  task automatic t_single();
    logic [7:0] d; bit seen; int n; logic [15:0] r;
    md_track = 1; md_inv = 1;
    wr(3'd2, 8'hA8);
    rd(3'd2, d);
    chk("R2 request reads 0", 32'(d), 32'h28);
    chk("R10 busy during conversion", 32'(busy), 1);
    rd(3'd7, d);
    chk("R10 C5 bit7 busy", 32'(d[7]), 1);
    wait_done(600, seen);
    chk("R3 done", 32'(seen), 1);
    #1; chk("R10 busy low at done", 32'(busy), 0);
    rd_res(r);
    chk("R5 2x32 tracking +", 32'(r), 32'd64);
    count_done(400, n);
    chk("R3 only one conversion", 32'(n), 0);
  endtask

  task automatic t_patterns();
    md_track = 0; md_const = 0;
    conv("R4 N0 M0 const0", 8'h80, 200, 16'hFFF8);
    md_const = 1;
    conv("R4 N0 M0 const1", 8'h80, 200, 16'h0008);
    conv("R4 chop cancel N2", 8'hC0, 400, 16'h0000);
    md_track = 1; md_inv = 1;
    conv("R5 N2 M1 track", 8'hC4, 800, 16'd64);
    md_inv = 0;
    conv("R5 N3 M7 full", 8'hFC, 40000, 16'hE000);
    wr(3'd2, 8'h28);
  endtask

  task automatic gap(input logic [7:0] c2, input int exp, input string req);
    int g = 0; bit go = 0;
    wr(3'd4, c2);
    for (int i = 0; i < 300 && !go; i++) begin @(negedge clk); #2; if (sample_stb) go = 1; end
    go = 0;
    for (int i = 0; i < 300 && !go; i++) begin @(negedge clk); #2; g++; if (sample_stb) go = 1; end
    chk(req, 32'(g), 32'(exp));
  endtask

  task automatic t_strobe();
    gap(8'h00, 4,  "R6 div4");
    gap(8'h40, 8,  "R6 div8");
    gap(8'h80, 32, "R6 div32");
    gap(8'hC0, 50, "R6 slow tick");
    wr(3'd4, 8'h00);
  endtask

  task automatic t_queue();
    int n;
    md_track = 0; md_const = 1;
    wr(3'd2, 8'hA8);
    repeat (5) @(negedge clk);
    wr(3'd2, 8'hA8);
    wr(3'd2, 8'hA8);
    count_done(1200, n);
    chk("R7 single queued request", 32'(n), 2);
    chk("R7 idle afterwards", 32'(busy), 0);
  endtask

  task automatic t_cont();
    int n;
    wr(3'd2, 8'h2A);
    count_done(1100, n);
    chk("R8 continuous re-arm", 32'(n >= 3), 1);
    wr(3'd2, 8'h28);
    count_done(400, n);
    count_done(600, n);
    chk("R8 stops after clear", 32'(n), 0);
    chk("R8 idle after clear", 32'(busy), 0);
  endtask

  task automatic t_enable();
    int n, s = 0; bit seen; logic [7:0] d;
    wr(3'd3, 8'hF0);
    chk("R9 mod_en low", 32'(mod_en), 0);
    chk("R9 amp_en pass 000", 32'(amp_en), 0);
    wr(3'd2, 8'hA8);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #2;
      if (sample_stb || busy || done) s++;
    end
    chk("R9 nothing while disabled", 32'(s), 0);
    wr(3'd3, 8'hFF);
    chk("R9 amp_en pass 111", 32'(amp_en), 32'h7);
    wait_done(600, seen);
    chk("R9 pending request kept", 32'(seen), 1);
    wr(3'd7, 8'hFF);
    rd(3'd7, d);
    chk("R10 C5 read back idle", 32'(d), 32'h7F);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ro_bits();
    t_single();
    t_patterns();
    t_strobe();
    t_queue();
    t_cont();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule